// File: doc/BRIEF.md
# Slave-Resettable Up-Counting Timer with Trigger Output

This block is an up-counting timer whose tick rate comes from a programmable clock divider and whose period comes from a top value. The counter runs from zero up to the top value inclusive, wraps to zero and raises an update event. A slave controller can clear the counter and the divider on the rising edge of a trigger. The trigger is taken either from an asynchronous external pin, which passes through a synchronizer first, or from the trigger output of another timer on the same clock. Several timers can therefore be chained.

A single-cycle trigger output reports update events to downstream logic. An update-source control decides whether a trigger-caused reset counts as an update. With the restricted setting, only a counter wrap or a software strobe produces an update, so slave resets stay silent on the trigger output. With the unrestricted setting, a trigger reset also produces an update, and its output pulse appears exactly one clock after the counter first reads zero. A software update strobe clears the counter and the divider, reloads the staged divider and top values, and, in reset mode, pulses the output in the same cycle. The divider and top inputs are staged: they take effect only at an update event.

The trigger-output sequencer is a four-state machine. IDLE means no pulse is pending. HOLD is entered after a trigger-caused update and waits one clock. FIRE_TRIG drives the delayed pulse for a trigger-caused update. FIRE_WRAP drives the pulse for a wrap update. The transitions are:
- any state goes to FIRE_WRAP on a wrap update that is not accompanied by the strobe;
- otherwise any state goes to HOLD on a trigger-caused update;
- otherwise HOLD goes to FIRE_TRIG, and every other state returns to IDLE.

Top module: `tmr_slave_timer`

## Requirements
- R1: After reset the counter output reads 0 and the trigger output is low.
- R2: With `cnt_en` high, the counter advances by one every `div_val`+1 clocks, as staged at the last update. It runs from 0 to the active top value inclusive, then reads 0 again.
- R3: In reset mode (`tout_mode` = 2'b00), a wrap produces a one-clock trigger-output pulse in the first cycle the counter reads 0 after the wrap.
- R4: A `sw_update` strobe clears the counter and the divider and reloads the staged values, so the counter reads 0 in the next cycle. In reset mode the trigger output is high in the same cycle as the strobe.
- R5: With `slv_rst_en` high, a rising edge of the selected trigger clears the counter and the divider, and the counter reads 0 in the next cycle. With `slv_rst_en` low, the trigger has no effect on the count.
- R6: `trig_src` = 0 selects the external pin. A rise first sampled at clock edge k clears the counter at edge k+2, through two synchronizer stages and a rising-edge detector. `trig_src` = 1 selects `chain_trig`: a rise first sampled at edge k clears the counter at edge k. The unselected source has no effect.
- R7: With `upd_ovf_only` low, a trigger-caused reset is an update. In reset mode the trigger output pulses for one clock, one cycle after the first cycle in which the counter reads 0.
- R8: With `upd_ovf_only` high, a trigger-caused reset is not an update: it reloads nothing and gives no trigger-output pulse. A pulse appears only at a later wrap, and never if every trigger arrives before the counter reaches the top value.
- R9: When a trigger reset and a wrap fall in the same cycle, exactly one update is produced. The counter reads 0 next, and there is a single pulse with wrap timing and no later trigger-timed pulse.
- R10: Changes to `div_val` and `top_val` have no effect until the next update event.
- R11: `tout_mode` = 2'b01 pulses the trigger output only for wrap updates, one cycle after the wrap. Strobes and trigger resets give no pulse in this mode. `tout_mode` = 2'b10 and 2'b11 hold the output low.
- R12: With `cnt_en` low, the counter and the divider hold their values. The strobe and the slave reset still clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counting enable |
| div_val | input | DIV_W | Staged divider value; tick rate is clk/(div_val+1) |
| top_val | input | CNT_W | Staged top value of the count |
| slv_rst_en | input | 1 | Enables the slave reset on trigger edges |
| trig_src | input | 1 | Trigger select: 0 external pin, 1 chained timer |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| chain_trig | input | 1 | Trigger output of another timer, same clock |
| upd_ovf_only | input | 1 | Restricts update sources to wrap and strobe |
| tout_mode | input | 2 | Trigger-output mode: 00 reset, 01 wrap only, 1x off |
| sw_update | input | 1 | Software update-generation strobe |
| cnt_o | output | CNT_W | Current counter value |
| trig_out | output | 1 | Single-cycle trigger output |

## Verification
A wrong divider or counter state shows at `cnt_o` within one tick period, as a value that skips, stalls or exceeds the top value. A wrong sequencer state shows at `trig_out` within two clocks of the event that caused it: a pulse one cycle early or late, a second pulse after a coincident wrap and trigger, or a pulse from a trigger reset under the restricted update source. A staged value that is loaded too early shows one period later, as a wrong wrap point on `cnt_o`.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // trigger-output sequencer states
    typedef enum logic [1:0] {
        TO_IDLE      = 2'b00,
        TO_HOLD      = 2'b01,
        TO_FIRE_WRAP = 2'b10,
        TO_FIRE_TRIG = 2'b11
    } tout_state_t;

    // trigger-output mode encodings
    localparam logic [1:0] TOUT_MODE_RESET = 2'b00;
    localparam logic [1:0] TOUT_MODE_WRAP  = 2'b01;

endpackage

// File: rtl/tmr_trig_sel.sv
module tmr_trig_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_trig,
    input  logic chain_trig,
    input  logic trig_src,
    input  logic slv_rst_en,
    output logic trig_hit
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ext_prev_q;
    logic                   chain_prev_q;
    logic                   ext_rise;
    logic                   chain_rise;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ext_trig;
            end
        end else begin : g_sync_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_trig};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_prev_q   <= 1'b0;
            chain_prev_q <= 1'b0;
        end else begin
            ext_prev_q   <= sync_q[LAST];
            chain_prev_q <= chain_trig;
        end
    end

    assign ext_rise   = sync_q[LAST] & ~ext_prev_q;
    assign chain_rise = chain_trig & ~chain_prev_q;
    assign trig_hit   = slv_rst_en & (trig_src ? chain_rise : ext_rise);

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             reinit,
    input  logic             load,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    logic [DIV_W-1:0] pcnt_q;
    logic [DIV_W-1:0] div_act_q;

    assign tick = cnt_en && (pcnt_q == div_act_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q    <= '0;
            div_act_q <= '0;
        end else begin
            if (reinit)      pcnt_q <= '0;
            else if (cnt_en) pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
            if (load)        div_act_q <= div_val;
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reinit,
    input  logic             load,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] top_act,
    output logic             wrap_evt
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_q;

    assign wrap_evt = tick && (cnt_q == top_q);
    assign cnt      = cnt_q;
    assign top_act  = top_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            top_q <= {CNT_W{1'b1}};
        end else begin
            if (reinit)        cnt_q <= '0;
            else if (wrap_evt) cnt_q <= '0;
            else if (tick)     cnt_q <= cnt_q + 1'b1;
            if (load)          top_q <= top_val;
        end
    end

endmodule

// File: rtl/tmr_tout_fsm.sv
module tmr_tout_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wrap_upd,
    input  logic       trig_upd,
    input  logic       sw_update,
    input  logic [1:0] tout_mode,
    output logic       trig_out
);

    tout_state_t state_q;
    tout_state_t state_d;
    logic        fire_wrap;
    logic        fire_trig;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TO_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        unique case (state_q)
            TO_IDLE:      state_d = TO_IDLE;
            TO_HOLD:      state_d = TO_FIRE_TRIG;
            TO_FIRE_WRAP: state_d = TO_IDLE;
            TO_FIRE_TRIG: state_d = TO_IDLE;
            default:      state_d = TO_IDLE;
        endcase
        if (trig_upd) state_d = TO_HOLD;
        if (wrap_upd) state_d = TO_FIRE_WRAP;
    end

    // outputs
    always_comb begin
        fire_wrap = 1'b0;
        fire_trig = 1'b0;
        unique case (state_q)
            TO_IDLE:      ;
            TO_HOLD:      ;
            TO_FIRE_WRAP: fire_wrap = 1'b1;
            TO_FIRE_TRIG: fire_trig = 1'b1;
            default:      ;
        endcase
        if (tout_mode == TOUT_MODE_RESET)
            trig_out = sw_update | fire_wrap | fire_trig;
        else if (tout_mode == TOUT_MODE_WRAP)
            trig_out = fire_wrap;
        else
            trig_out = 1'b0;
    end

endmodule

// File: rtl/tmr_slave_timer.sv
module tmr_slave_timer #(
    parameter int DIV_W       = 16,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [DIV_W-1:0] div_val,
    input  logic [CNT_W-1:0] top_val,
    input  logic             slv_rst_en,
    input  logic             trig_src,
    input  logic             ext_trig,
    input  logic             chain_trig,
    input  logic             upd_ovf_only,
    input  logic [1:0]       tout_mode,
    input  logic             sw_update,
    output logic [CNT_W-1:0] cnt_o,
    output logic             trig_out
);

    logic             trig_hit;
    logic             tick;
    logic             wrap_evt;
    logic             reinit;
    logic             upd_evt;
    logic             wrap_upd;
    logic             trig_upd;
    logic [CNT_W-1:0] top_act;

    // one update per cycle; the strobe outranks the wrap, the wrap outranks the trigger
    assign reinit   = sw_update | trig_hit;
    assign upd_evt  = sw_update | wrap_evt | (trig_hit & ~upd_ovf_only);
    assign wrap_upd = wrap_evt & ~sw_update;
    assign trig_upd = trig_hit & ~upd_ovf_only & ~wrap_evt & ~sw_update;

    tmr_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) u_trig_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_trig   (ext_trig),
        .chain_trig (chain_trig),
        .trig_src   (trig_src),
        .slv_rst_en (slv_rst_en),
        .trig_hit   (trig_hit)
    );

    tmr_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .reinit  (reinit),
        .load    (upd_evt),
        .div_val (div_val),
        .tick    (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .reinit   (reinit),
        .load     (upd_evt),
        .top_val  (top_val),
        .cnt      (cnt_o),
        .top_act  (top_act),
        .wrap_evt (wrap_evt)
    );

    tmr_tout_fsm u_tout (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap_upd  (wrap_upd),
        .trig_upd  (trig_upd),
        .sw_update (sw_update),
        .tout_mode (tout_mode),
        .trig_out  (trig_out)
    );

endmodule

// File: rtl/tmr_slave_timer_chk.sv
module tmr_slave_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             sw_update,
    input logic             upd_ovf_only,
    input logic [1:0]       tout_mode,
    input logic [CNT_W-1:0] cnt_o,
    input logic             trig_out,
    input logic             tick,
    input logic             trig_hit,
    input logic             wrap_evt,
    input logic [CNT_W-1:0] top_act
);

    // R2: a tick below the top value advances the count by one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !trig_hit && !sw_update && cnt_o != top_act) |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R2: the count never passes the active top value
    p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= top_act);

    // R3: a wrap in reset mode is followed by a pulse
    p_wrap_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_evt && !sw_update && tout_mode == 2'b00) |=> (trig_out || tout_mode != 2'b00));

    // R4: the strobe clears the counter
    p_strobe_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sw_update |=> (cnt_o == '0));

    // R5: a slave trigger clears the counter
    p_trig_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |=> (cnt_o == '0));

    // R7: a trigger update pulses two clocks after the edge
    p_trig_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && !upd_ovf_only && !wrap_evt && !sw_update) |=> ##1 (trig_out || tout_mode != 2'b00));

    // R8: under the restricted source a trigger reset reloads nothing
    p_no_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && upd_ovf_only && !wrap_evt && !sw_update) |=> $stable(top_act));

    // R9: coincident wrap and trigger give no trigger-timed second pulse
    p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && wrap_evt && !sw_update) |=> ##1 (!trig_out || sw_update || $past(wrap_evt)));

    // R11: modes 1x keep the output low
    p_mode_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tout_mode[1] |-> !trig_out);

    // R12: disabled counting holds the count
    p_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !trig_hit && !sw_update) |=> $stable(cnt_o));

endmodule

bind tmr_slave_timer tmr_slave_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_en       (cnt_en),
    .sw_update    (sw_update),
    .upd_ovf_only (upd_ovf_only),
    .tout_mode    (tout_mode),
    .cnt_o        (cnt_o),
    .trig_out     (trig_out),
    .tick         (tick),
    .trig_hit     (trig_hit),
    .wrap_evt     (wrap_evt),
    .top_act      (top_act)
);

// File: tb/tmr_slave_timer_tb.sv
module tmr_slave_timer_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    cyc;
        bit    use_cnt;
        int    cnt;
        bit    tout;
        string tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [15:0] div_val = '0;
    logic [15:0] top_val = 16'd9;
    logic        slv_rst_en = 1'b1;
    logic        trig_src = 1'b1;
    logic        ext_trig = 1'b0;
    logic        chain_trig = 1'b0;
    logic        upd_ovf_only = 1'b0;
    logic [1:0]  tout_mode = 2'b00;
    logic        sw_update = 1'b0;
    logic [15:0] cnt_o;
    logic        trig_out;

    int       cyc = 0;
    int       n_checks = 0;
    int       n_fail = 0;
    int       base = 0;
    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tmr_slave_timer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_en       (cnt_en),
        .div_val      (div_val),
        .top_val      (top_val),
        .slv_rst_en   (slv_rst_en),
        .trig_src     (trig_src),
        .ext_trig     (ext_trig),
        .chain_trig   (chain_trig),
        .upd_ovf_only (upd_ovf_only),
        .tout_mode    (tout_mode),
        .sw_update    (sw_update),
        .cnt_o        (cnt_o),
        .trig_out     (trig_out)
    );

    // monitor: compare due items at the falling edge
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].cyc == cyc) begin
                n_checks++;
                if ((sb_q[i].use_cnt && int'(cnt_o) != sb_q[i].cnt) || trig_out !== sb_q[i].tout) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d: actual cnt=%0d tout=%0b, expected cnt=%0s tout=%0b",
                             sb_q[i].tag, cyc, cnt_o, trig_out,
                             sb_q[i].use_cnt ? $sformatf("%0d", sb_q[i].cnt) : "any", sb_q[i].tout);
                end
                sb_q.delete(i);
            end
        end
    end

    task automatic step_to(int tgt);
        while (cyc < tgt) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic exp_at(int at, bit use_cnt, int cnt, bit tout, string tag);
        sb_item_t it;
        it.cyc = at; it.use_cnt = use_cnt; it.cnt = cnt; it.tout = tout; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic strobe(int dv, int tv);
        div_val   = 16'(dv);
        top_val   = 16'(tv);
        sw_update = 1'b1;
        base      = cyc;
    endtask

    task automatic chain_at(int at);
        step_to(at);
        chain_trig = 1'b1;
        step_to(at + 1);
        chain_trig = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        step_to(3);
        rst_n = 1'b1;
        base  = cyc;
        // R1: reset state
        exp_at(base + 1, 1, 0, 0, "R1");
        exp_at(base + 2, 1, 0, 0, "R1");
        step_to(base + 3);

        // R4 and R3: strobe, then count 0..5 and wrap with pulse
        cnt_en = 1'b1;
        strobe(0, 5);
        exp_at(base, 0, 0, 1, "R4 strobe pulse");
        exp_at(base + 1, 1, 0, 0, "R4 strobe clear");
        exp_at(base + 3, 1, 2, 0, "R2 count");
        exp_at(base + 6, 1, 5, 0, "R2 top reached");
        exp_at(base + 7, 1, 0, 1, "R3 wrap pulse");
        exp_at(base + 8, 1, 1, 0, "R3 single pulse");
        step_to(base + 1); sw_update = 1'b0;
        step_to(base + 9);

        // R2: divider 2, top 3
        strobe(2, 3);
        exp_at(base + 1, 1, 0, 0, "R2 div");
        exp_at(base + 3, 1, 0, 0, "R2 div hold");
        exp_at(base + 4, 1, 1, 0, "R2 div step");
        exp_at(base + 10, 1, 3, 0, "R2 div top");
        exp_at(base + 12, 1, 3, 0, "R2 div top hold");
        exp_at(base + 13, 1, 0, 1, "R3 div wrap");
        step_to(base + 1); sw_update = 1'b0;
        step_to(base + 15);

        // R10: staged top value takes effect only after the wrap
        strobe(0, 3);
        exp_at(base + 4, 1, 3, 0, "R10 old top");
        exp_at(base + 5, 1, 0, 1, "R10 wrap at old top");
        exp_at(base + 11, 1, 6, 0, "R10 new top");
        exp_at(base + 12, 1, 0, 1, "R10 wrap at new top");
        step_to(base + 1); sw_update = 1'b0; top_val = 16'd6;
        step_to(base + 13);

        // R12: disabled counting holds
        strobe(0, 9);
        exp_at(base + 3, 1, 2, 0, "R12 before");
        exp_at(base + 4, 1, 2, 0, "R12 hold");
        exp_at(base + 6, 1, 2, 0, "R12 hold");
        exp_at(base + 7, 1, 3, 0, "R12 resume");
        step_to(base + 1); sw_update = 1'b0;
        step_to(base + 3); cnt_en = 1'b0;
        step_to(base + 6); cnt_en = 1'b1;
        step_to(base + 8);

        // R5 and R7: chained trigger, unrestricted source
        strobe(0, 20);
        exp_at(base + 5, 1, 4, 0, "R5 before");
        exp_at(base + 6, 1, 0, 0, "R7 clear no pulse yet");
        exp_at(base + 7, 1, 1, 1, "R7 delayed pulse");
        exp_at(base + 8, 1, 2, 0, "R7 one clock");
        step_to(base + 1); sw_update = 1'b0;
        chain_at(base + 5);
        step_to(base + 9);

        // R8: restricted source, triggers before the top give no pulse
        upd_ovf_only = 1'b1;
        strobe(0, 5);
        exp_at(base + 4, 1, 0, 0, "R8 clear");
        exp_at(base + 5, 1, 1, 0, "R8 no pulse");
        exp_at(base + 8, 1, 1, 0, "R8 no pulse");
        exp_at(base + 11, 1, 1, 0, "R8 no pulse");
        exp_at(base + 15, 1, 5, 0, "R8 no reload");
        exp_at(base + 16, 1, 0, 1, "R8 pulse at wrap");
        step_to(base + 1); sw_update = 1'b0; top_val = 16'd20;
        chain_at(base + 3);
        chain_at(base + 6);
        chain_at(base + 9);
        step_to(base + 17);
        upd_ovf_only = 1'b0;

        // R5: slave disabled, trigger ignored
        slv_rst_en = 1'b0;
        strobe(0, 20);
        exp_at(base + 4, 1, 3, 0, "R5 disabled");
        exp_at(base + 5, 1, 4, 0, "R5 disabled");
        step_to(base + 1); sw_update = 1'b0;
        chain_at(base + 3);
        step_to(base + 6);
        slv_rst_en = 1'b1;

        // R6: external pin through the synchronizer, chain input ignored
        trig_src = 1'b0;
        strobe(0, 30);
        exp_at(base + 6, 1, 5, 0, "R6 sync delay");
        exp_at(base + 7, 1, 0, 0, "R6 ext clear");
        exp_at(base + 8, 1, 1, 1, "R6 R7 ext pulse");
        exp_at(base + 13, 1, 6, 0, "R6 unselected chain");
        step_to(base + 1); sw_update = 1'b0;
        step_to(base + 4); ext_trig = 1'b1;
        step_to(base + 10); ext_trig = 1'b0;
        chain_at(base + 12);
        step_to(base + 14);
        trig_src = 1'b1;

        // R9: wrap and trigger in the same cycle
        strobe(0, 4);
        exp_at(base + 5, 1, 4, 0, "R9 at top");
        exp_at(base + 6, 1, 0, 1, "R9 single update");
        exp_at(base + 7, 1, 1, 0, "R9 no second pulse");
        exp_at(base + 8, 1, 2, 0, "R9 no second pulse");
        step_to(base + 1); sw_update = 1'b0;
        chain_at(base + 5);
        step_to(base + 9);

        // R11: wrap-only output mode
        tout_mode = 2'b01;
        strobe(0, 3);
        exp_at(base, 0, 0, 0, "R11 no strobe pulse");
        exp_at(base + 5, 1, 0, 1, "R11 wrap pulse");
        exp_at(base + 8, 1, 0, 0, "R11 trig clear");
        exp_at(base + 9, 1, 1, 0, "R11 no trig pulse");
        step_to(base + 1); sw_update = 1'b0;
        chain_at(base + 7);
        step_to(base + 10);

        // R11: output off mode
        tout_mode = 2'b10;
        strobe(0, 3);
        exp_at(base, 0, 0, 0, "R11 off strobe");
        exp_at(base + 5, 1, 0, 0, "R11 off wrap");
        step_to(base + 1); sw_update = 1'b0;
        step_to(base + 7);

        step_to(cyc + 3);
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb_q.size());
        end
        summary();
        $finish;
    end

endmodule